// File: doc/BRIEF.md
# Synchronous Serial Shift Port with Octal Bit Counter

This block moves one 8-bit word at a time over a three-wire synchronous link: a shift clock, a data-out line and a data-in line. The word is loaded as two 4-bit halves and read back as one byte once the transfer ends. A 3-bit counter tracks the bits. Its wrap back to zero after the eighth clock marks the end of the word and raises a completion flag.

The shift clock can come from outside the chip. It can also be made inside, either from the system clock at full rate or from the system clock divided by one of three prescaler ratios. Software selects the source with a mode write. Every mode write puts the port back into a start-wait state, and a start command then arms it. While the port waits or is idle, the data-out line holds a programmable level.

The flag reacts in a defined way when the port is pulled out of a transfer by a mode write. In external-clock mode, software uses this to detect a noise pulse that was counted as a clock. It clears the flag, writes the mode and checks whether the flag comes back.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, state_o is 2'b00 (start-wait), flag_o is 0, data_o is 0, so_o is 0, sck_o is 1, sck_oe_o is 0 and the clock source is external.
- R2: A lo_wr_i pulse loads nib_i into data bits 3:0 and a hi_wr_i pulse loads it into bits 7:4. data_o shows the word. Both loads are ignored while state_o is 2'b10.
- R3: mode_src_i 2'b00 selects the external clock on sck_i, 2'b01 the prescaler and 2'b10 or 2'b11 the system clock. With an internal source, sck_oe_o is 1 and sck_o gives exactly eight low pulses per word, then rests high.
- R4: With the prescaler, mode_div_i 2'b00, 2'b01 and 2'b1x give a shift-clock period of 128, 512 and 2048 system clocks. In system-clock mode the period is 2 system clocks. A word takes 16 half periods after the start command.
- R5: state_o encodes start-wait as 2'b00, clock-wait as 2'b01 and transfer as 2'b10. A start_i pulse in start-wait moves to clock-wait. The first falling shift-clock edge in clock-wait moves to transfer.
- R6: Data leaves LSB first on so_o. The line changes on falling shift-clock edges, and si_i is sampled on rising edges into bit 7 while the word shifts right.
- R7: On the eighth rising edge of a transfer the counter wraps to zero and flag_o is set. The port then goes to clock-wait with the external source and to start-wait with an internal one. In clock-wait, a further external falling edge starts a new transfer.
- R8: A mode_wr_i pulse returns the port to start-wait and clears the bit counter. It sets flag_o when it arrives in transfer and leaves flag_o unchanged in any other state.
- R9: Outside transfer, so_o equals the last value written with idle_wr_i/idle_lvl_i (0 low, 1 high).
- R10: Shift-clock edges on sck_i in start-wait have no effect on the state, the data or the flag.
- R11: flag_clr_i clears flag_o; a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_src_i | input | 2 | Clock source code taken on a mode write |
| mode_div_i | input | 2 | Prescaler ratio code taken on a mode write |
| idle_wr_i | input | 1 | Idle-level write strobe |
| idle_lvl_i | input | 1 | Data-out level outside transfer |
| lo_wr_i | input | 1 | Load strobe for data bits 3:0 |
| hi_wr_i | input | 1 | Load strobe for data bits 7:4 |
| nib_i | input | 4 | Nibble for the load strobes |
| start_i | input | 1 | Start command |
| flag_clr_i | input | 1 | Completion flag clear |
| sck_i | input | 1 | External shift clock, synchronous to clk_i |
| si_i | input | 1 | Serial data in |
| sck_o | output | 1 | Internal shift clock |
| sck_oe_o | output | 1 | Drive enable for sck_o |
| so_o | output | 1 | Serial data out |
| data_o | output | 8 | Data word |
| flag_o | output | 1 | Completion flag |
| state_o | output | 2 | Port state code |

## Verification
An externally clocked word with distinct send and receive patterns shows the bit order on so_o and the sampling into data_o. A data load in the middle of that word shows that loads are locked out. An external sequence with one extra glitch pulse shows the early completion. The real eighth clock then restarts a transfer, so a following mode write raises the flag again, while the same mode write after a clean word does not. Internally clocked words in loopback run at each clock rate, and their length measured in cycles tells the prescaler ratios apart. A mode write part-way through an internal word shows the abort, the flag and the partly rotated data.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_CKWAIT = 2'b01,
    ST_XFER   = 2'b10
  } ssp_state_e;

  typedef enum logic [1:0] {
    SRC_EXT = 2'b00,
    SRC_PRE = 2'b01,
    SRC_SYS = 2'b10
  } ssp_src_e;
endpackage

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
module ssp_clkgen #(
  parameter int unsigned DIV_A = 128,
  parameter int unsigned DIV_B = 512,
  parameter int unsigned DIV_C = 2048
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clr_i,
  input  logic       sys_i,
  input  logic [1:0] div_sel_i,
  output logic       sck_o,
  output logic       fall_o,
  output logic       rise_o
);
  localparam int unsigned HA   = DIV_A / 2;
  localparam int unsigned HB   = DIV_B / 2;
  localparam int unsigned HC   = DIV_C / 2;
  localparam int unsigned HMAX = (HA > HB) ? ((HA > HC) ? HA : HC) : ((HB > HC) ? HB : HC);
  localparam int unsigned HW   = (HMAX > 1) ? $clog2(HMAX) : 1;

  logic [HW-1:0] hc_q, lim;
  logic          tick;

  always_comb begin
    if (sys_i) lim = '0;
    else begin
      case (div_sel_i)
        2'b00:   lim = HW'(HA - 1);
        2'b01:   lim = HW'(HB - 1);
        default: lim = HW'(HC - 1);
      endcase
    end
  end

  assign tick   = run_i && !clr_i && (hc_q == lim);
  assign fall_o = tick && sck_o;
  assign rise_o = tick && !sck_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q  <= '0;
      sck_o <= 1'b1;
    end else if (!run_i || clr_i) begin
      hc_q  <= '0;
      sck_o <= 1'b1;
    end else if (tick) begin
      hc_q  <= '0;
      sck_o <= ~sck_o;
    end else begin
      hc_q  <= hc_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssp_extedge.sv
`timescale 1ns/1ps
module ssp_extedge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sck_i,
  output logic fall_o,
  output logic rise_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b1;
    else         sck_q <= sck_i;
  end

  assign fall_o = en_i && sck_q && !sck_i;
  assign rise_o = en_i && !sck_q && sck_i;
endmodule

// File: rtl/ssp_shifter.sv
`timescale 1ns/1ps
module ssp_shifter #(
  parameter int unsigned W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           launch_i,
  input  logic           active_i,
  input  logic           fall_i,
  input  logic           rise_i,
  input  logic           si_i,
  input  logic           lo_wr_i,
  input  logic           hi_wr_i,
  input  logic [W/2-1:0] nib_i,
  output logic [W-1:0]   data_o,
  output logic           so_bit_o,
  output logic           done_o
);
  localparam int unsigned CW = $clog2(W);
  localparam int unsigned H  = W / 2;

  logic [CW-1:0] cnt_q;

  assign done_o = active_i && rise_i && (cnt_q == CW'(W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      so_bit_o <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (launch_i || (active_i && fall_i)) so_bit_o <= data_o[0];
      if (active_i && rise_i) begin
        data_o <= {si_i, data_o[W-1:1]};
      end else if (!active_i) begin
        if (lo_wr_i) data_o[H-1:0] <= nib_i;
        if (hi_wr_i) data_o[W-1:H] <= nib_i;
      end
      // counter wraps to zero on the last bit
      if (clr_i)                   cnt_q <= '0;
      else if (active_i && rise_i) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_serial_port.sv
`timescale 1ns/1ps
module sync_serial_port #(
  parameter int unsigned W     = 8,
  parameter int unsigned DIV_A = 128,
  parameter int unsigned DIV_B = 512,
  parameter int unsigned DIV_C = 2048
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           mode_wr_i,
  input  logic [1:0]     mode_src_i,
  input  logic [1:0]     mode_div_i,
  input  logic           idle_wr_i,
  input  logic           idle_lvl_i,
  input  logic           lo_wr_i,
  input  logic           hi_wr_i,
  input  logic [W/2-1:0] nib_i,
  input  logic           start_i,
  input  logic           flag_clr_i,
  input  logic           sck_i,
  input  logic           si_i,
  output logic           sck_o,
  output logic           sck_oe_o,
  output logic           so_o,
  output logic [W-1:0]   data_o,
  output logic           flag_o,
  output logic [1:0]     state_o
);
  import ssp_pkg::*;

  ssp_state_e st_q, st_d;
  ssp_src_e   src_q, src_new;
  logic [1:0] div_q;
  logic       idle_q, flag_set;
  logic       ext, run_int;
  logic       i_fall, i_rise, e_fall, e_rise, fall, rise;
  logic       launch, active, done, so_bit;

  assign ext     = (src_q == SRC_EXT);
  assign run_int = !ext && (st_q != ST_IDLE);

  always_comb begin
    case (mode_src_i)
      2'b00:   src_new = SRC_EXT;
      2'b01:   src_new = SRC_PRE;
      default: src_new = SRC_SYS;
    endcase
  end

  ssp_clkgen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_clkgen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_int),
    .clr_i     (mode_wr_i),
    .sys_i     (src_q != SRC_PRE),
    .div_sel_i (div_q),
    .sck_o     (sck_o),
    .fall_o    (i_fall),
    .rise_o    (i_rise)
  );

  ssp_extedge u_extedge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ext && (st_q != ST_IDLE)),
    .sck_i  (sck_i),
    .fall_o (e_fall),
    .rise_o (e_rise)
  );

  assign fall   = ext ? e_fall : i_fall;
  assign rise   = ext ? e_rise : i_rise;
  assign launch = (st_q == ST_CKWAIT) && fall && !mode_wr_i;
  assign active = (st_q == ST_XFER);

  ssp_shifter #(.W(W)) u_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (mode_wr_i),
    .launch_i (launch),
    .active_i (active),
    .fall_i   (fall),
    .rise_i   (rise),
    .si_i     (si_i),
    .lo_wr_i  (lo_wr_i),
    .hi_wr_i  (hi_wr_i),
    .nib_i    (nib_i),
    .data_o   (data_o),
    .so_bit_o (so_bit),
    .done_o   (done)
  );

  always_comb begin
    st_d     = st_q;
    flag_set = 1'b0;
    if (mode_wr_i) begin
      st_d     = ST_IDLE;
      flag_set = (st_q == ST_XFER);
    end else begin
      case (st_q)
        ST_IDLE:   if (start_i) st_d = ST_CKWAIT;
        ST_CKWAIT: if (fall)    st_d = ST_XFER;
        ST_XFER: if (done) begin
          flag_set = 1'b1;
          st_d     = ext ? ST_CKWAIT : ST_IDLE;
        end
        default:   st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      src_q  <= SRC_EXT;
      div_q  <= 2'b00;
      idle_q <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (mode_wr_i) begin
        src_q <= src_new;
        div_q <= mode_div_i;
      end
      if (idle_wr_i) idle_q <= idle_lvl_i;
      if (flag_set)        flag_o <= 1'b1;
      else if (flag_clr_i) flag_o <= 1'b0;
    end
  end

  assign sck_oe_o = !ext;
  assign so_o     = active ? so_bit : idle_q;
  assign state_o  = st_q;
endmodule

// File: rtl/ssp_chk.sv
`timescale 1ns/1ps
module ssp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_wr_i,
  input logic       idle_wr_i,
  input logic       idle_lvl_i,
  input logic       start_i,
  input logic       flag_clr_i,
  input logic       sck_o,
  input logic       so_o,
  input logic       flag_o,
  input logic [1:0] state_o
);
  // R5
  state_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != 2'b11);

  // R8
  mode_wr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> state_o == 2'b00);

  // R9
  idle_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_wr_i && !mode_wr_i) |=> (state_o == 2'b10 || so_o == $past(idle_lvl_i)));

  // R7
  flag_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(state_o) == 2'b10);

  // R3
  sck_rest_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'b00 |-> sck_o);

  // R11
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && state_o == 2'b00) |=> !flag_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'b00 && !start_i && !mode_wr_i) |=> state_o == 2'b00);
endmodule

bind sync_serial_port ssp_chk u_ssp_chk (.*);

// File: tb/sync_serial_port_bench.sv
`timescale 1ns/1ps
module sync_serial_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 0, idle_wr = 0, idle_lvl = 0, lo_wr = 0, hi_wr = 0;
  logic       start = 0, flag_clr = 0, sck_in = 1'b1, si_drv = 0, lb = 0;
  logic [1:0] mode_src = 0, mode_div = 0;
  logic [3:0] nib = 0;
  logic       si, sck_o, sck_oe, so, flag;
  logic [7:0] data;
  logic [1:0] state;

  int n_cmp = 0, n_bad = 0;
  logic [7:0] expq[$];
  logic [7:0] mon_e;
  logic       flag_prev = 1'b0;

  always #2.5 clk = ~clk;
  assign si = lb ? so : si_drv;

  sync_serial_port u_sync_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_src_i(mode_src),
    .mode_div_i(mode_div), .idle_wr_i(idle_wr), .idle_lvl_i(idle_lvl),
    .lo_wr_i(lo_wr), .hi_wr_i(hi_wr), .nib_i(nib), .start_i(start),
    .flag_clr_i(flag_clr), .sck_i(sck_in), .si_i(si), .sck_o(sck_o),
    .sck_oe_o(sck_oe), .so_o(so), .data_o(data), .flag_o(flag), .state_o(state)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_mode(input logic [1:0] s, input logic [1:0] d);
    mode_src = s; mode_div = d; mode_wr = 1; cyc(1); mode_wr = 0;
  endtask

  task automatic set_idle(input logic v);
    idle_lvl = v; idle_wr = 1; cyc(1); idle_wr = 0;
  endtask

  task automatic load(input logic [7:0] v);
    nib = v[3:0]; lo_wr = 1; cyc(1); lo_wr = 0;
    nib = v[7:4]; hi_wr = 1; cyc(1); hi_wr = 0;
  endtask

  task automatic pulse_start();
    start = 1; cyc(1); start = 0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1; cyc(1); flag_clr = 0;
  endtask

  task automatic ext_bit(input logic si_v, input logic exp_so, input logic do_chk);
    sck_in = 0; cyc(2);
    if (do_chk) chk("R6 so bit on falling edge", so, exp_so);
    si_drv = si_v; sck_in = 1; cyc(2);
  endtask

  task automatic int_run(input logic [1:0] s, input logic [1:0] d, input logic [7:0] v,
                         input int exp_cyc, input string tag);
    int  n;
    int  falls;
    logic prev;
    lb = 1;
    do_mode(s, d);
    load(v);
    expq.push_back(v);
    pulse_start();
    n = 1; falls = 0; prev = sck_o;
    while (!flag && n < 20000) begin
      cyc(1); n++;
      if (prev && !sck_o) falls++;
      prev = sck_o;
    end
    chk({tag, " word length in range"}, (n >= exp_cyc - 2 && n <= exp_cyc + 2), 1);
    chk("R3 eight internal clock pulses", falls, 8);
    chk("R3 clock rests high", sck_o, 1);
    chk("R3 clock driven", sck_oe, 1);
    chk("R7 internal completion to start-wait", state, 2'b00);
    pulse_clr();
    lb = 0;
  endtask

  // scoreboard monitor: each flag rise consumes one expected word
  always @(negedge clk) begin
    if (rst_n && flag && !flag_prev) begin
      if (expq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R7 unexpected flag actual=%0h expected=none", data);
      end else begin
        mon_e = expq.pop_front();
        chk("R7 received word at flag", data, mon_e);
      end
    end
    flag_prev = flag;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1
    chk("R1 reset state", state, 2'b00);
    chk("R1 reset flag", flag, 0);
    chk("R1 reset data", data, 8'h00);
    chk("R1 reset so", so, 0);
    chk("R1 reset sck_o", sck_o, 1);
    chk("R1 reset sck_oe", sck_oe, 0);

    // R9
    set_idle(1);
    chk("R9 idle high", so, 1);

    // R2
    load(8'hA5);
    chk("R2 nibble load", data, 8'hA5);

    // R10: external edges in start-wait
    for (int i = 0; i < 4; i++) begin
      sck_in = 0; cyc(2); sck_in = 1; cyc(2);
    end
    chk("R10 state held", state, 2'b00);
    chk("R10 data held", data, 8'hA5);
    chk("R10 flag held", flag, 0);

    // R5, R6: clean external word, tx A5 rx 3C
    pulse_start();
    chk("R5 start to clock-wait", state, 2'b01);
    expq.push_back(8'h3C);
    for (int i = 0; i < 8; i++) begin
      ext_bit(((8'h3C >> i) & 1) != 0, ((8'hA5 >> i) & 1) != 0, 1);
      if (i == 0) chk("R5 falling edge to transfer", state, 2'b10);
      if (i == 2) begin
        nib = 4'hF; lo_wr = 1; cyc(1); lo_wr = 0;
      end
    end
    chk("R2 load ignored in transfer", data, 8'h3C);
    chk("R7 external completion to clock-wait", state, 2'b01);
    chk("R7 flag set", flag, 1);
    chk("R9 idle level after word", so, 1);
    pulse_clr();
    chk("R11 flag cleared", flag, 0);
    do_mode(2'b00, 2'b00);
    chk("R8 mode write outside transfer keeps flag", flag, 0);
    chk("R8 mode write to start-wait", state, 2'b00);

    // noise: one glitch counted as a clock
    set_idle(0);
    chk("R9 idle low", so, 0);
    load(8'h0F);
    si_drv = 1;
    pulse_start();
    expq.push_back(8'hFF);
    for (int i = 0; i < 4; i++) ext_bit(1, 1, 1);
    sck_in = 0; cyc(1); sck_in = 1; cyc(1);
    for (int i = 0; i < 3; i++) ext_bit(1, 0, 0);
    chk("R7 early completion flag", flag, 1);
    chk("R7 early completion state", state, 2'b01);
    ext_bit(1, 0, 0);
    chk("R7 extra clock restarts transfer", state, 2'b10);
    pulse_clr();
    chk("R11 flag cleared before probe", flag, 0);
    expq.push_back(8'hFF);
    do_mode(2'b00, 2'b00);
    chk("R8 mode write in transfer sets flag", flag, 1);
    chk("R8 mode write in transfer to start-wait", state, 2'b00);
    pulse_clr();

    // R3, R4: internal clocks in loopback
    int_run(2'b10, 2'b00, 8'h5A, 17,    "R4 system clock");
    int_run(2'b01, 2'b00, 8'hC3, 1025,  "R4 divide 128");
    int_run(2'b01, 2'b01, 8'h96, 4097,  "R4 divide 512");
    int_run(2'b01, 2'b10, 8'h3E, 16385, "R4 divide 2048");

    // R8: abort an internal word after two bits
    lb = 1;
    do_mode(2'b01, 2'b00);
    load(8'h81);
    pulse_start();
    cyc(299);
    chk("R5 internal word in transfer", state, 2'b10);
    expq.push_back(8'h60);
    do_mode(2'b01, 2'b00);
    chk("R8 abort sets flag", flag, 1);
    chk("R8 abort to start-wait", state, 2'b00);
    chk("R3 clock high after abort", sck_o, 1);
    lb = 0;
    pulse_clr();

    cyc(4);
    chk("R7 all expected words seen", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule